// File: doc/BRIEF.md
# Two-Channel Prescaled Interval and Watchdog Timer

This block is a timer peripheral holding two channels that run independently of one another. Each channel divides the system clock with its own programmable prescaler. It then counts a down-counter from a programmed reload value. When the counter runs past zero the channel expires. What happens next depends on the selected mode: the channel reloads and continues, it stops after one expiry, or it acts as a watchdog that requests a system reset unless software services it in time.

Software reaches the block through a simple synchronous write port and a combinational read port. Each channel occupies eight word slots. The upper address bits select the channel and the low three bits select the register. Every expiry sets a sticky per-channel flag, and an enable bit gates that flag onto the interrupt line. A channel started in watchdog mode cannot be stopped or reconfigured by software until the next reset.

Top module: `twin_timer`

## Requirements
- R1: After reset every readable register of every channel reads 0, and all interrupt and reset-request outputs are low.
- R2: With prescale value P and reload value R written, a start write at clock edge S makes the first expiry happen at edge S + (P+1)·(R+1). The prescaler produces one tick every P+1 clocks, and the counter decrements on each tick and expires on the tick that finds it at zero.
- R3: In free-running mode (mode code 0, or the reserved code 3), each expiry sets the flag and reloads the counter with the reload value, so the counter reads R right after an expiry and expiries recur every (P+1)·(R+1) clocks.
- R4: In one-shot mode (mode code 1), the first expiry sets the flag, clears the run bit and leaves the counter at 0. No further expiry occurs.
- R5: In watchdog mode (mode code 2), an expiry sets the flag and raises the channel's reset-request output. That output stays high until reset. It also reads as status bit 1.
- R6: Writing 0x5A to the kick register (offset 5) of a running channel reloads the counter and restarts the prescaler phase. Any other value written there leaves the counter unaffected.
- R7: The expiry flag (status offset 4, bit 0) stays set until a write of 1 to that bit clears it. Writing 0 has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: A channel's interrupt output equals its flag ANDed with its enable bit (control offset 0, bit 3).
- R9: Once a channel runs in watchdog mode, writes to its control register (offset 0: bit 0 run, bits 2:1 mode, bit 3 enable) are ignored until reset.
- R10: Address bits [3] select the channel and bits [2:0] the register (0 control, 1 prescale, 2 reload, 3 count, 4 status, 5 kick). Activity on one channel has no effect on the other.
- R11: Writing 0 to the run bit outside watchdog mode halts the channel at that edge without a decrement on that edge. The count then holds its value.
- R12: The count register (offset 3) is read-only. Writes to it do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| wr_addr | input | AW (4) | Write address: channel select above, register offset in bits 2:0 |
| wr_data | input | CW (32) | Write data |
| rd_addr | input | AW (4) | Read address, same layout as wr_addr |
| rd_data | output | CW (32) | Combinational read data for rd_addr |
| irq | output | NCH (2) | Per-channel interrupt, flag AND enable |
| wd_rst_req | output | NCH (2) | Per-channel sticky watchdog reset request |

## Verification
Every register write takes effect at the edge that samples it. A channel started at edge S first expires at edge S+(P+1)(R+1), and the flag, the interrupt and the reset request are all visible from that edge on. The bench numbers the edges with a counter and takes the start edge from that counter. It samples only at falling edges, so each timing check compares the measured edge distance against the product it computes itself. For the watchdog case the bench checks that the request is still low one edge before the predicted expiry and high at it. That pins down both the kick-induced reload and the rejection of a wrong key to the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_WDOG = 2'd2,
    MODE_RSVD = 2'd3
  } tmr_mode_e;

  // register slots within one channel window (R10)
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_PRESC  = 3'd1;
  localparam logic [2:0] OFS_RELOAD = 3'd2;
  localparam logic [2:0] OFS_COUNT  = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_KICK   = 3'd5;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] limit,
  output logic          tick
);

  logic [PW-1:0] phase_q;

  function automatic logic phase_done(input logic [PW-1:0] ph, input logic [PW-1:0] lim);
    return ph >= lim;
  endfunction

  assign tick = run && !restart && phase_done(phase_q, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || restart || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  // R2
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int          CW  = 32,
  parameter int          PW  = 32,
  parameter logic [7:0]  KEY = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_presc,
  input  logic          wr_reload,
  input  logic          wr_status,
  input  logic          wr_kick,
  input  logic [CW-1:0] wdata,
  input  logic [2:0]    rd_ofs,
  output logic [CW-1:0] rd_word,
  output logic          irq,
  output logic          wd_req
);

  logic          run_q;
  logic          ie_q;
  tmr_mode_e     mode_q;
  logic [PW-1:0] presc_q;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] count_q;
  logic          flag_q;
  logic          wd_q;

  // named internal events
  logic locked;
  logic ctrl_accept;
  logic start;
  logic kick_ok;
  logic tick;
  logic expire;

  function automatic logic [CW-1:0] count_after_tick(input logic [CW-1:0] cur,
                                                     input logic [CW-1:0] rel,
                                                     input tmr_mode_e     m);
    if (cur != '0)          return cur - CW'(1);
    else if (m == MODE_ONCE) return '0;
    else                     return rel;
  endfunction

  assign locked      = run_q && (mode_q == MODE_WDOG);
  assign ctrl_accept = wr_ctrl && !locked;
  assign start       = ctrl_accept && wdata[CTRL_RUN_BIT];
  assign kick_ok     = wr_kick && run_q && (wdata[7:0] == KEY);
  assign expire      = tick && (count_q == '0) && !ctrl_accept && !kick_ok;

  tmr_prescaler #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (start || kick_ok),
    .limit   (presc_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= MODE_FREE;
    end else if (ctrl_accept) begin
      run_q  <= wdata[CTRL_RUN_BIT];
      ie_q   <= wdata[CTRL_IE_BIT];
      mode_q <= tmr_mode_e'(wdata[2:1]);
    end else if (expire && mode_q == MODE_ONCE) begin
      run_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q  <= '0;
      reload_q <= '0;
    end else begin
      if (wr_presc)  presc_q  <= PW'(wdata);
      if (wr_reload) reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start) begin
      count_q <= reload_q;
    end else if (ctrl_accept) begin
      count_q <= count_q;
    end else if (kick_ok) begin
      count_q <= reload_q;
    end else if (tick) begin
      count_q <= count_after_tick(count_q, reload_q, mode_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wd_q   <= 1'b0;
    end else begin
      if (expire)                      flag_q <= 1'b1;
      else if (wr_status && wdata[0])  flag_q <= 1'b0;
      if (expire && mode_q == MODE_WDOG) wd_q <= 1'b1;
    end
  end

  assign irq    = flag_q && ie_q;
  assign wd_req = wd_q;

  always_comb begin
    unique case (rd_ofs)
      OFS_CTRL:   rd_word = CW'({ie_q, mode_q, run_q});
      OFS_PRESC:  rd_word = CW'(presc_q);
      OFS_RELOAD: rd_word = reload_q;
      OFS_COUNT:  rd_word = count_q;
      OFS_STATUS: rd_word = CW'({wd_q, flag_q});
      default:    rd_word = '0;
    endcase
  end

  // R2
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q != '0 && !ctrl_accept && !kick_ok) |=> count_q == $past(count_q) - CW'(1));

  // R3
  free_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_q != MODE_ONCE) |=> (count_q == $past(reload_q) && flag_q));

  // R4
  once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode_q == MODE_ONCE) |=> (!run_q && count_q == '0));

  // R5
  wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |=> wd_req);

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kick && wdata[7:0] != KEY && !tick && !wr_ctrl) |=> count_q == $past(count_q));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_status && wdata[0])) |=> flag_q);

  // R9
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tmr_pkg::*;
#(
  parameter int         NCH = 2,
  parameter int         CW  = 32,
  parameter int         PW  = 32,
  parameter logic [7:0] KEY = 8'h5A,
  localparam int        SELW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int        AW   = SELW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] irq,
  output logic [NCH-1:0] wd_rst_req
);

  logic [CW-1:0] rd_words [NCH];
  logic [2:0]    wr_ofs;

  assign wr_ofs = wr_addr[2:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (wr_addr[AW-1:3] == SELW'(i));

    tmr_channel #(.CW(CW), .PW(PW), .KEY(KEY)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && wr_ofs == OFS_CTRL),
      .wr_presc  (hit && wr_ofs == OFS_PRESC),
      .wr_reload (hit && wr_ofs == OFS_RELOAD),
      .wr_status (hit && wr_ofs == OFS_STATUS),
      .wr_kick   (hit && wr_ofs == OFS_KICK),
      .wdata     (wr_data),
      .rd_ofs    (rd_addr[2:0]),
      .rd_word   (rd_words[i]),
      .irq       (irq[i]),
      .wd_req    (wd_rst_req[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr[AW-1:3] == SELW'(i)) rd_data = rd_words[i];
    end
  end

endmodule

// File: tb/twin_timer_tb.sv
`timescale 1ns/1ps
module twin_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [1:0]  irq;
  logic [1:0]  wd_rst_req;

  int cyc = 0;
  int vecs = 0;
  int bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twin_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wd_rst_req(wd_rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int ch, input int ofs, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'((ch << 3) | ofs); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int ofs, output logic [31:0] d);
    rd_addr = 4'((ch << 3) | ofs);
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_flag(input int ch);
    logic [31:0] d;
    for (int n = 0; n < 400; n++) begin
      rd(ch, 4, d);
      if (d[0]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int s, t, n, k, target;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int ofs = 0; ofs < 5; ofs++) begin
        rd(ch, ofs, d);
        chk("R1", d, 0);
      end
    chk("R1", 32'(irq), 0);
    chk("R1", 32'(wd_rst_req), 0);

    // R2/R3 free-running sweep on channel 0
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) begin
        n = (p + 1) * (r + 1);
        wr(0, 1, 32'(p));
        wr(0, 2, 32'(r));
        wr(0, 0, 32'h9);
        s = cyc;
        wait_flag(0);
        chk("R2", 32'(cyc - s), 32'(n));
        chk("R8", 32'(irq[0]), 1);
        rd(0, 3, d);
        chk("R3", d, 32'(r));
        wr(0, 4, 1);
        wait_flag(0);
        chk("R3", 32'(cyc - s), 32'(2 * n));
        wr(0, 0, 0);
        wr(0, 4, 1);
        rd(0, 4, d);
        chk("R7", d, 0);
      end

    // R10 channel 1 untouched by channel 0 traffic
    rd(1, 3, d);
    chk("R10", d, 0);
    chk("R10", 32'(irq[1]), 0);

    // R4 one-shot
    for (int p = 0; p < 4; p += 2)
      for (int r = 0; r < 4; r += 3) begin
        n = (p + 1) * (r + 1);
        wr(0, 1, 32'(p));
        wr(0, 2, 32'(r));
        wr(0, 0, 32'hB);
        s = cyc;
        wait_flag(0);
        chk("R4", 32'(cyc - s), 32'(n));
        repeat (2) @(negedge clk);
        rd(0, 0, d);
        chk("R4", d, 32'hA);
        wr(0, 0, 32'h2);
        chk("R8", 32'(irq[0]), 0);
        rd(0, 4, d);
        chk("R8", d[0], 1);
        wr(0, 4, 1);
        repeat (n + 3) @(negedge clk);
        rd(0, 4, d);
        chk("R4", d, 0);
        rd(0, 3, d);
        chk("R4", d, 0);
      end

    // R7 write 0 ignored, set wins over clear
    wr(0, 1, 0);
    wr(0, 2, 0);
    wr(0, 0, 32'h1);
    repeat (2) @(negedge clk);
    wr(0, 4, 0);
    rd(0, 4, d);
    chk("R7", d[0], 1);
    wr(0, 4, 1);
    rd(0, 4, d);
    chk("R7", d[0], 1);
    chk("R8", 32'(irq[0]), 0);
    wr(0, 0, 0);
    wr(0, 4, 1);
    rd(0, 4, d);
    chk("R7", d[0], 0);

    // R11 stop holds count, R12 count is read-only
    wr(0, 2, 100);
    wr(0, 0, 32'h1);
    s = cyc;
    repeat (9) @(negedge clk);
    wr(0, 0, 0);
    t = cyc - s;
    rd(0, 3, d);
    chk("R11", d, 32'(100 - (t - 1)));
    repeat (5) @(negedge clk);
    rd(0, 3, d2);
    chk("R11", d2, d);
    wr(0, 3, 32'h1234);
    rd(0, 3, d2);
    chk("R12", d2, d);

    // R5/R6/R9 watchdog on channel 1
    wr(1, 1, 1);
    wr(1, 2, 5);
    wr(1, 0, 32'hD);
    s = cyc;
    wr(1, 0, 0);
    rd(1, 0, d);
    chk("R9", d, 32'hD);
    wr(1, 5, 32'h5B);
    rd(1, 3, d);
    chk("R6", d, 4);
    wr(1, 5, 32'h5A);
    k = cyc;
    rd(1, 3, d);
    chk("R6", d, 5);
    target = k + 12;
    while (cyc < target - 1) @(negedge clk);
    chk("R6", 32'(wd_rst_req[1]), 0);
    @(negedge clk);
    chk("R5", 32'(wd_rst_req[1]), 1);
    chk("R5", 32'(irq[1]), 1);
    rd(1, 4, d);
    chk("R5", d, 3);
    repeat (20) @(negedge clk);
    chk("R5", 32'(wd_rst_req[1]), 1);
    rd(1, 0, d);
    chk("R9", d, 32'hD);
    chk("R10", 32'(wd_rst_req[0]), 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", 32'(wd_rst_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule